// File: doc/BRIEF.md
# Point-Multiplier Register Front End

This block sits between a simple synchronous register bus and an elliptic-curve point-multiplier engine. Software writes a 256-bit scalar as eight 32-bit words into an input bank. It starts an operation by writing the control register, first with the start bit clear and then with it set. It polls the status register until the result flag is set, then reads the X and Y coordinates of the result from two output banks of eight words each.

On the engine side the block provides a one-cycle start pulse and a combinational word-indexed read port into the scalar bank. It also has a word write port into the two result banks. It takes the engine's idle indication and a one-cycle completion pulse. Identification words are parameters. The engine itself is not part of the block.

Top module: `ecmul_regfront`

## Requirements
- R1: Reads of word address 0x00, 0x01 and 0x02 return the parameters ID_NAME0, ID_NAME1 and ID_VERSION.
- R2: A read of any address outside 0x00–0x02, 0x08, 0x09 and 0x20–0x37 returns zero.
- R3: Bus writes to 0x20+i (i = 0..7) store word i of the scalar, and word 0 is the least significant 32 bits. Bus reads return the stored word. `eng_k_word` shows word `eng_k_idx` in the same cycle.
- R4: A write to 0x08 with bit 1 set, while the stored bit 1 is 0, raises `eng_start` for exactly one cycle, the cycle after the write. A write with bit 1 set while the stored bit is already 1 gives no pulse.
- R5: Status bit 1 (result valid) is 0 after reset and clears together with the start pulse. It is set on the edge after an `eng_done` pulse and stays set until the next start.
- R6: Status bit 0 equals `eng_ready` at the time of the read. All other status bits read 0.
- R7: The engine writes X word i at 0x28+i (`eng_res_sel`=0) and Y word i at 0x30+i (`eng_res_sel`=1). The bus reads them there, and bus writes to these addresses leave them unchanged.
- R8: Bus writes to the identification and status addresses have no effect on what those addresses read.
- R9: `bus_rdata` is registered. It is updated on the clock edge of a read access and holds its value otherwise. After reset it is 0, and `eng_start` is 0.
- R10: A read of 0x08 returns the stored start bit in bit 1 and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_start | output | 1 | One-cycle operation start |
| eng_ready | input | 1 | Engine idle |
| eng_done | input | 1 | One-cycle completion pulse |
| eng_k_idx | input | 3 | Scalar word index |
| eng_k_word | output | 32 | Scalar word at `eng_k_idx` |
| eng_res_we | input | 1 | Result word write |
| eng_res_sel | input | 1 | 0 = X bank, 1 = Y bank |
| eng_res_idx | input | 3 | Result word index |
| eng_res_word | input | 32 | Result word data |

## Verification
The hardest case to reach is a second start request while the stored start bit is still 1. That write must produce no pulse and must leave the valid flag alone. The bench reaches it by writing the bit set twice in a row after a completed operation. It checks that no pulse appears and that status still reads valid. It then writes zero followed by the bit set, and observes through the status register that valid clears before the engine stub completes the second operation with a different scalar.

// File: rtl/ecmul_regfront_pkg.sv
package ecmul_regfront_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_NAME0 = 6'h00;
  localparam logic [ADDR_W-1:0] A_NAME1 = 6'h01;
  localparam logic [ADDR_W-1:0] A_VER   = 6'h02;
  localparam logic [ADDR_W-1:0] A_CTRL  = 6'h08;
  localparam logic [ADDR_W-1:0] A_STAT  = 6'h09;

  // bank pages: address bits [5:3]
  localparam logic [2:0] PG_K = 3'd4;
  localparam logic [2:0] PG_X = 3'd5;
  localparam logic [2:0] PG_Y = 3'd6;

  localparam int BIT_NEXT  = 1;
  localparam int BIT_VALID = 1;
  localparam int BIT_READY = 0;
endpackage

// File: rtl/ecmul_regfront_bank.sv
module ecmul_regfront_bank #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IW-1:0]      widx,
  input  logic [W-1:0]       wdata,
  output logic [DEPTH*W-1:0] all_q
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic          en;
    logic [W-1:0]  d;
    logic [W-1:0]  q;
    always_comb begin
      en = we && (widx == IW'(g));
      d  = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end
    assign all_q[g*W +: W] = q;
  end
endmodule

// File: rtl/ecmul_regfront_ctrl.sv
module ecmul_regfront_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic ctrl_bit,
  input  logic eng_done,
  output logic next_q,
  output logic start_q,
  output logic valid_q
);
  logic next_d, start_d, valid_d;

  always_comb begin
    next_d  = ctrl_wr ? ctrl_bit : next_q;
    start_d = ctrl_wr && ctrl_bit && !next_q;
    if (start_d)       valid_d = 1'b0;
    else if (eng_done) valid_d = 1'b1;
    else               valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q  <= 1'b0;
      start_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      next_q  <= next_d;
      start_q <= start_d;
      valid_q <= valid_d;
    end
  end
endmodule

// File: rtl/ecmul_regfront.sv
module ecmul_regfront
  import ecmul_regfront_pkg::*;
#(
  parameter logic [31:0] ID_NAME0   = 32'h65636d75,
  parameter logic [31:0] ID_NAME1   = 32'h6c323536,
  parameter logic [31:0] ID_VERSION = 32'h00010000,
  parameter int          WORDS      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        eng_start,
  input  logic        eng_ready,
  input  logic        eng_done,
  input  logic [2:0]  eng_k_idx,
  output logic [31:0] eng_k_word,
  input  logic        eng_res_we,
  input  logic        eng_res_sel,
  input  logic [2:0]  eng_res_idx,
  input  logic [31:0] eng_res_word
);
  localparam int IW   = $clog2(WORDS);
  localparam int BANK = WORDS * DATA_W;

  logic            rd_acc, wr_acc;
  logic [2:0]      page;
  logic [IW-1:0]   idx;
  logic [BANK-1:0] k_all, x_all, y_all;
  logic            next_q, valid_q;
  logic [31:0]     rd_d, rdata_q;

  assign rd_acc = bus_sel && !bus_wr;
  assign wr_acc = bus_sel && bus_wr;
  assign page   = bus_addr[5:3];
  assign idx    = bus_addr[IW-1:0];

  ecmul_regfront_bank #(.W(DATA_W), .DEPTH(WORDS)) u_kbank (
    .clk(clk), .rst_n(rst_n),
    .we(wr_acc && page == PG_K), .widx(idx), .wdata(bus_wdata),
    .all_q(k_all));

  ecmul_regfront_bank #(.W(DATA_W), .DEPTH(WORDS)) u_xbank (
    .clk(clk), .rst_n(rst_n),
    .we(eng_res_we && !eng_res_sel), .widx(eng_res_idx), .wdata(eng_res_word),
    .all_q(x_all));

  ecmul_regfront_bank #(.W(DATA_W), .DEPTH(WORDS)) u_ybank (
    .clk(clk), .rst_n(rst_n),
    .we(eng_res_we && eng_res_sel), .widx(eng_res_idx), .wdata(eng_res_word),
    .all_q(y_all));

  ecmul_regfront_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(wr_acc && bus_addr == A_CTRL),
    .ctrl_bit(bus_wdata[BIT_NEXT]),
    .eng_done(eng_done),
    .next_q(next_q), .start_q(eng_start), .valid_q(valid_q));

  assign eng_k_word = k_all[eng_k_idx*DATA_W +: DATA_W];

  always_comb begin
    rd_d = '0;
    case (page)
      PG_K: rd_d = k_all[idx*DATA_W +: DATA_W];
      PG_X: rd_d = x_all[idx*DATA_W +: DATA_W];
      PG_Y: rd_d = y_all[idx*DATA_W +: DATA_W];
      default: begin
        case (bus_addr)
          A_NAME0: rd_d = ID_NAME0;
          A_NAME1: rd_d = ID_NAME1;
          A_VER:   rd_d = ID_VERSION;
          A_CTRL:  rd_d[BIT_NEXT] = next_q;
          A_STAT: begin
            rd_d[BIT_VALID] = valid_q;
            rd_d[BIT_READY] = eng_ready;
          end
          default: rd_d = '0;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_acc) rdata_q <= rd_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/ecmul_regfront_chk.sv
module ecmul_regfront_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [5:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        eng_start,
  input logic        eng_done,
  input logic        valid_q
);
  logic unmapped;
  always_comb
    unmapped = !(bus_addr <= 6'h02 || bus_addr == 6'h08 || bus_addr == 6'h09 ||
                 (bus_addr >= 6'h20 && bus_addr <= 6'h37));

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R4

  AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_start) |-> $past(bus_sel && bus_wr && bus_addr == 6'h08 && bus_wdata[1])); // R4

  AST_VALID_CLEARED_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !valid_q); // R5

  AST_VALID_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(eng_done)); // R5

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata)); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && unmapped) |=> bus_rdata == 32'h0); // R2
endmodule

bind ecmul_regfront ecmul_regfront_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .eng_start(eng_start), .eng_done(eng_done), .valid_q(valid_q));

// File: tb/ecmul_regfront_tb_top.sv
module ecmul_regfront_tb_top;
  localparam logic [31:0] N0 = 32'h11223344;
  localparam logic [31:0] N1 = 32'h55667788;
  localparam logic [31:0] VR = 32'h0002000a;
  localparam int NV = 10;
  // {address, expected read data} with engine idle and no result yet
  localparam logic [37:0] VEC [NV] = '{
    {6'h00, N0}, {6'h01, N1}, {6'h02, VR},              // R1
    {6'h03, 32'h0}, {6'h07, 32'h0}, {6'h0a, 32'h0},    // R2
    {6'h1f, 32'h0}, {6'h38, 32'h0}, {6'h3f, 32'h0},    // R2
    {6'h09, 32'h1}                                     // R6: ready=1, valid=0
  };

  logic clk, rst_n;
  logic bus_sel, bus_wr;
  logic [5:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic eng_start, eng_ready, eng_done;
  logic [2:0] eng_k_idx, eng_res_idx;
  logic [31:0] eng_k_word, eng_res_word;
  logic eng_res_we, eng_res_sel;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  ecmul_regfront #(.ID_NAME0(N0), .ID_NAME1(N1), .ID_VERSION(VR)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_start(eng_start), .eng_ready(eng_ready), .eng_done(eng_done),
    .eng_k_idx(eng_k_idx), .eng_k_word(eng_k_word),
    .eng_res_we(eng_res_we), .eng_res_sel(eng_res_sel),
    .eng_res_idx(eng_res_idx), .eng_res_word(eng_res_word));

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  // engine stub: X word = k ^ A5A5A5A5, Y word = k + index
  task automatic run_engine(input logic [255:0] k);
    logic [31:0] r;
    eng_ready = 0;
    @(negedge clk);
    bus_read(6'h09, r);
    chk("R6 status while busy", r, 32'h0);
    for (int i = 0; i < 8; i++) begin
      eng_k_idx = 3'(i);
      #1;
      chk("R3 engine scalar port", eng_k_word, k[i*32 +: 32]);
      eng_res_we = 1; eng_res_sel = 0; eng_res_idx = 3'(i);
      eng_res_word = eng_k_word ^ 32'ha5a5a5a5;
      @(negedge clk);
      eng_res_sel = 1; eng_res_word = k[i*32 +: 32] + 32'(i);
      @(negedge clk);
      eng_res_we = 0;
    end
    eng_done = 1;
    @(negedge clk);
    eng_done = 0; eng_ready = 1;
  endtask

  task automatic start_op;
    bus_write(6'h08, 32'h0);
    bus_write(6'h08, 32'h2);
  endtask

  task automatic check_results(input logic [255:0] k);
    logic [31:0] r;
    for (int i = 0; i < 8; i++) begin
      bus_read(6'h28 + 6'(i), r);
      chk("R7 X word", r, k[i*32 +: 32] ^ 32'ha5a5a5a5);
      bus_read(6'h30 + 6'(i), r);
      chk("R7 Y word", r, k[i*32 +: 32] + 32'(i));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [255:0] k1, k2;
    k1 = {32'h8899aabb, 32'h01234567, 32'hdeadbeef, 32'h0badf00d,
          32'hcafef00d, 32'h13579bdf, 32'h2468ace0, 32'hfedcba98};
    k2 = {32'h00000001, 32'h10000000, 32'h7fffffff, 32'h80000000,
          32'hffffffff, 32'h00000000, 32'h5a5a5a5a, 32'h00000003};
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    eng_ready = 1; eng_done = 0; eng_k_idx = 0; eng_res_we = 0;
    eng_res_sel = 0; eng_res_idx = 0; eng_res_word = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset rdata", bus_rdata, 32'h0);
    chk("R9 reset start", 32'(eng_start), 32'h0);

    // table walk: R1 R2 R6
    for (int v = 0; v < NV; v++) begin
      bus_read(VEC[v][37:32], r);
      chk(VEC[v][37:32] < 6'h03 ? "R1 ident" : (VEC[v][37:32] == 6'h09 ? "R6 status" : "R2 unmapped"),
          r, VEC[v][31:0]);
    end

    // R3 scalar load, word 0 least significant
    for (int i = 0; i < 8; i++) bus_write(6'h20 + 6'(i), k1[i*32 +: 32]);
    for (int i = 0; i < 8; i++) begin
      bus_read(6'h20 + 6'(i), r);
      chk("R3 scalar readback", r, k1[i*32 +: 32]);
    end

    // R4 start pulse
    bus_write(6'h08, 32'h0);
    chk("R4 no start on zero write", 32'(eng_start), 32'h0);
    bus_write(6'h08, 32'h2);
    chk("R4 start pulse", 32'(eng_start), 32'h1);
    @(negedge clk);
    chk("R4 start one cycle", 32'(eng_start), 32'h0);
    bus_read(6'h08, r);
    chk("R10 control readback", r, 32'h2);

    run_engine(k1);
    bus_read(6'h09, r);
    chk("R5 R6 status after done", r, 32'h3);
    check_results(k1);

    // R7 R8 writes to read-only locations
    bus_write(6'h28, 32'hffffffff);
    bus_write(6'h31, 32'hffffffff);
    bus_write(6'h00, 32'h0);
    bus_write(6'h09, 32'h0);
    bus_read(6'h28, r);
    chk("R7 X write ignored", r, k1[31:0] ^ 32'ha5a5a5a5);
    bus_read(6'h31, r);
    chk("R7 Y write ignored", r, k1[63:32] + 32'd1);
    bus_read(6'h00, r);
    chk("R8 name write ignored", r, N0);
    bus_read(6'h09, r);
    chk("R8 status write ignored", r, 32'h3);

    // R9 rdata hold through idle and writes
    repeat (3) @(negedge clk);
    chk("R9 hold idle", bus_rdata, 32'h3);
    bus_write(6'h21, 32'h0);
    chk("R9 hold on write", bus_rdata, 32'h3);
    bus_write(6'h21, k1[63:32]);

    // R4 repeated set while stored bit is 1: no pulse, valid kept
    bus_write(6'h08, 32'h2);
    chk("R4 no pulse when already set", 32'(eng_start), 32'h0);
    @(negedge clk);
    chk("R4 still no pulse", 32'(eng_start), 32'h0);
    bus_read(6'h09, r);
    chk("R5 valid kept without start", r, 32'h3);

    // second operation: R5 valid clears on start
    for (int i = 0; i < 8; i++) bus_write(6'h20 + 6'(i), k2[i*32 +: 32]);
    start_op();
    chk("R4 second start", 32'(eng_start), 32'h1);
    bus_read(6'h09, r);
    chk("R5 valid cleared by start", r, 32'h1);
    run_engine(k2);
    bus_read(6'h09, r);
    chk("R5 valid set again", r, 32'h3);
    check_results(k2);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule